// File: doc/BRIEF.md
# UART modem handshake registers

This block holds the modem-control and modem-status registers of a 16550-style serial port. It drives the active-low RTS and DTR handshake outputs from the control register. It brings the active-low CTS, DSR and DCD lines into the clock domain and shows their asserted state in the status register. Each line also has a change flag that records any movement since the status register was last read. When enabled, the change flags raise a modem-status interrupt.

A loop-back mode disconnects the handshake outputs and feeds four control bits back into the status register, so that software can test the port without a modem. At the end of reset the block samples a strap level and selects one of two configuration index base addresses from it.

The register interface uses a 3-bit offset, single-cycle read and write strobes and 8-bit data. Read data is combinational on the offset.

Top module: `mdm_hs_regs`

## Requirements
- R1: While `rst_ni` is low, `rts_no` and `dtr_no` are high, `msi_o` is low, the control register reads 0x00 and the status register reads 0x00.
- R2: With loop-back off, control bit 0 at offset 4 drives `dtr_no` low when 1 and high when 0. Control bit 1 does the same for `rts_no`. The pins follow the first clock edge after the write.
- R3: With control bit 4 (loop-back) set, `rts_no` and `dtr_no` are high, whatever bits 0 and 1 hold.
- R4: With loop-back off, status bits 4, 5 and 7 at offset 6 read the complement of `cts_ni`, `dsr_ni` and `dcd_ni`. A pin change appears after SYNC_STAGES clock edges. Bits 2 and 6 read 0.
- R5: Status bits 0 (CTS), 1 (DSR) and 3 (DCD) set to 1 one edge after the matching status bit changes in either direction. They stay set until a status read.
- R6: A status read returns the change flags as they stood, and clears them at the edge that ends the read cycle. A change detected in the read cycle itself is still set afterwards.
- R7: `msi_o` is high when interrupt-enable bit 3 (offset 1) is 1 and any change flag is set. It stays high until a status read or a clear of that enable bit.
- R8: In loop-back, status bit 4 reads control bit 1, bit 5 reads bit 0, bit 6 reads bit 2 and bit 7 reads bit 3, with no delay. The external CTS, DSR and DCD pins have no effect on the status register in this mode.
- R9: `cfg_base_o` is CFG_BASE_0 (0x3F0) while reset is held. At the first clock edge after reset is released, it takes CFG_BASE_0 if `rts_strap_i` is 0 and CFG_BASE_1 (0x370) if it is 1. It then holds that value until the next reset.
- R10: Offset 1 reads back interrupt-enable bits 3:0, and offset 4 reads back control bits 4:0. Unused upper bits read 0. Other offsets read 0x00, and writes to the status offset or to unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the offset on addr_i |
| cts_ni | input | 1 | Clear-to-send from modem, active low |
| dsr_ni | input | 1 | Data-set-ready from modem, active low |
| dcd_ni | input | 1 | Carrier detect from modem, active low |
| rts_no | output | 1 | Request-to-send to modem, active low |
| dtr_no | output | 1 | Data-terminal-ready to modem, active low |
| rts_strap_i | input | 1 | Strap level sampled when reset is released |
| cfg_base_o | output | 16 | Selected configuration index base address |
| msi_o | output | 1 | Modem-status interrupt |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. Pin-to-status latency therefore becomes three edges and pin-to-flag latency four, which exposes any logic or expectation hard-wired to a two-stage chain. The address parameters keep their defaults. Two resets, one with each strap level, reach both base values. A directed read that lands in exactly the cycle a synchronized change arrives covers the no-lost-event case of the read clear.

// File: rtl/mdm_hs_pkg.sv
package mdm_hs_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] OFF_IER = 3'd1;
  localparam logic [REG_AW-1:0] OFF_MCR = 3'd4;
  localparam logic [REG_AW-1:0] OFF_MSR = 3'd6;

  // control register fields
  localparam int unsigned MCR_DTR  = 0;
  localparam int unsigned MCR_RTS  = 1;
  localparam int unsigned MCR_OUT1 = 2;
  localparam int unsigned MCR_OUT2 = 3;
  localparam int unsigned MCR_LOOP = 4;
  localparam int unsigned MCR_W    = 5;

  localparam int unsigned IER_MSI  = 3;
  localparam int unsigned IER_W    = 4;

  // modem line vector, asserted-high
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_DCD = 2;
  localparam int unsigned LN_W   = 3;

  localparam int unsigned CFG_W  = 16;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] state_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] chg_o,
  output logic [WIDTH-1:0] delta_o
);
  logic [WIDTH-1:0] prev_q, delta_q;

  assign chg_o = state_i ^ prev_q;

  // same-cycle change survives a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= state_i;
      delta_q <= (clr_i ? '0 : delta_q) | chg_o;
    end
  end

  assign delta_o = delta_q;
endmodule

// File: rtl/mdm_strap.sv
module mdm_strap #(
  parameter int unsigned  BW    = 16,
  parameter logic [BW-1:0] BASE0 = 16'h03F0,
  parameter logic [BW-1:0] BASE1 = 16'h0370
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_i,
  output logic [BW-1:0] base_o,
  output logic          done_o
);
  logic sel_q, done_q;

  // sample once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      sel_q  <= strap_i;
      done_q <= 1'b1;
    end
  end

  assign base_o = sel_q ? BASE1 : BASE0;
  assign done_o = done_q;
endmodule

// File: rtl/mdm_hs_regs.sv
module mdm_hs_regs
  import mdm_hs_pkg::*;
#(
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [15:0]     CFG_BASE_0  = 16'h03F0,
  parameter logic [15:0]     CFG_BASE_1  = 16'h0370
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        cts_ni,
  input  logic        dsr_ni,
  input  logic        dcd_ni,
  output logic        rts_no,
  output logic        dtr_no,
  input  logic        rts_strap_i,
  output logic [15:0] cfg_base_o,
  output logic        msi_o
);
  logic [MCR_W-1:0] mcr_q;
  logic [IER_W-1:0] ier_q;
  logic [LN_W-1:0]  pin_n, sync_n, line_s, chg, delta_q;
  logic             loop_en, ri_s, msr_rd, strap_done;
  logic [REG_DW-1:0] msr;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[REG_DW-1:MCR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcr_q <= '0;
      ier_q <= '0;
    end else if (wr_i) begin
      if (addr_i == OFF_MCR) mcr_q <= wdata_i[MCR_W-1:0];
      if (addr_i == OFF_IER) ier_q <= wdata_i[IER_W-1:0];
    end
  end

  assign loop_en = mcr_q[MCR_LOOP];
  assign rts_no  = ~(mcr_q[MCR_RTS] & ~loop_en);
  assign dtr_no  = ~(mcr_q[MCR_DTR] & ~loop_en);

  assign pin_n[LN_CTS] = cts_ni;
  assign pin_n[LN_DSR] = dsr_ni;
  assign pin_n[LN_DCD] = dcd_ni;

  mdm_sync #(
    .WIDTH  (LN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_n),
    .q_o   (sync_n)
  );

  // loop-back enters after the synchronizer: MCR is already synchronous
  always_comb begin
    if (loop_en) begin
      line_s[LN_CTS] = mcr_q[MCR_RTS];
      line_s[LN_DSR] = mcr_q[MCR_DTR];
      line_s[LN_DCD] = mcr_q[MCR_OUT2];
    end else begin
      line_s = ~sync_n;
    end
  end
  assign ri_s = loop_en & mcr_q[MCR_OUT1];

  assign msr_rd = rd_i && (addr_i == OFF_MSR);

  mdm_delta #(.WIDTH(LN_W)) u_delta (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(line_s),
    .clr_i  (msr_rd),
    .chg_o  (chg),
    .delta_o(delta_q)
  );

  assign msr = {line_s[LN_DCD], ri_s, line_s[LN_DSR], line_s[LN_CTS],
                delta_q[LN_DCD], 1'b0, delta_q[LN_DSR], delta_q[LN_CTS]};

  always_comb begin
    unique case (addr_i)
      OFF_IER: rdata_o = {{(REG_DW-IER_W){1'b0}}, ier_q};
      OFF_MCR: rdata_o = {{(REG_DW-MCR_W){1'b0}}, mcr_q};
      OFF_MSR: rdata_o = msr;
      default: rdata_o = '0;
    endcase
  end

  assign msi_o = ier_q[IER_MSI] & (|delta_q);

  mdm_strap #(
    .BW   (CFG_W),
    .BASE0(CFG_BASE_0),
    .BASE1(CFG_BASE_1)
  ) u_strap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strap_i(rts_strap_i),
    .base_o (cfg_base_o),
    .done_o (strap_done)
  );
endmodule

// File: rtl/mdm_hs_chk.sv
module mdm_hs_chk
  import mdm_hs_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  addr_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  wdata_i,
  input logic        rts_no,
  input logic        dtr_no,
  input logic        msi_o,
  input logic [15:0] cfg_base_o,
  input logic [2:0]  chg_i,
  input logic [2:0]  delta_i,
  input logic        strap_done_i
);
  // R2 R3
  mcr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_MCR) |=>
      (rts_no == !($past(wdata_i[MCR_RTS]) && !$past(wdata_i[MCR_LOOP]))) &&
      (dtr_no == !($past(wdata_i[MCR_DTR]) && !$past(wdata_i[MCR_LOOP]))));

  // R5
  delta_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i != '0) |=> ((delta_i & $past(chg_i)) == $past(chg_i)));

  // R6
  delta_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_MSR && chg_i == '0) |=> (delta_i == '0));

  // R7
  msi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_o && !(rd_i && addr_i == OFF_MSR) && !(wr_i && addr_i == OFF_IER)) |=> msi_o);

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done_i |=> $stable(cfg_base_o));
endmodule

bind mdm_hs_regs mdm_hs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .wdata_i     (wdata_i),
  .rts_no      (rts_no),
  .dtr_no      (dtr_no),
  .msi_o       (msi_o),
  .cfg_base_o  (cfg_base_o),
  .chg_i       (chg),
  .delta_i     (delta_q),
  .strap_done_i(strap_done)
);

// File: tb/tb_mdm_hs_regs.sv
`timescale 1ns/1ps
module tb_mdm_hs_regs;
  localparam int unsigned SYNC = 3;
  localparam logic [15:0] B0 = 16'h03F0;
  localparam logic [15:0] B1 = 16'h0370;

  logic clk = 1'b0, rst_n = 1'b1;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, strap = 1'b0;
  logic rts_n, dtr_n, msi;
  logic [15:0] cfg;
  int vecs = 0, errs = 0;
  bit chk_en = 1'b0;

  always #2.5 clk = ~clk;

  mdm_hs_regs #(.SYNC_STAGES(SYNC), .CFG_BASE_0(B0), .CFG_BASE_1(B1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .cts_ni(cts_n), .dsr_ni(dsr_n),
    .dcd_ni(dcd_n), .rts_no(rts_n), .dtr_no(dtr_n), .rts_strap_i(strap),
    .cfg_base_o(cfg), .msi_o(msi)
  );

  // reference state, {dcd,dsr,cts} order
  logic [2:0] m_sync [SYNC];
  logic [2:0] m_prev, m_delta;
  logic [4:0] m_mcr;
  logic [3:0] m_ier;
  logic m_done;
  logic [15:0] m_cfg;

  function automatic logic [2:0] m_line();
    if (m_mcr[4]) return {m_mcr[3], m_mcr[0], m_mcr[1]};
    return ~m_sync[SYNC-1];
  endfunction

  function automatic logic [7:0] m_rdata(input logic [2:0] a);
    logic [2:0] s;
    s = m_line();
    case (a)
      3'd1: return {4'b0, m_ier};
      3'd4: return {3'b0, m_mcr};
      3'd6: return {s[2], m_mcr[4] & m_mcr[2], s[1], s[0], m_delta[2], 1'b0, m_delta[1], m_delta[0]};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [2:0] s;
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) m_sync[i] <= 3'b111;
      m_prev <= '0; m_delta <= '0; m_mcr <= '0; m_ier <= '0;
      m_done <= 1'b0; m_cfg <= B0;
    end else begin
      s = m_line();
      m_sync[0] <= {dcd_n, dsr_n, cts_n};
      for (int i = 1; i < SYNC; i++) m_sync[i] <= m_sync[i-1];
      m_prev  <= s;
      m_delta <= ((rd && addr == 3'd6) ? 3'b000 : m_delta) | (s ^ m_prev);
      if (wr && addr == 3'd4) m_mcr <= wdata[4:0];
      if (wr && addr == 3'd1) m_ier <= wdata[3:0];
      if (!m_done) begin
        m_done <= 1'b1;
        m_cfg  <= strap ? B1 : B0;
      end
    end
  end

  task automatic cmp(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      cmp({8'h0, rdata}, {8'h0, m_rdata(addr)}, (addr == 3'd6) ? "R4 R5 R6 R8 msr" : "R10 readback");
      cmp({15'h0, rts_n}, {15'h0, !(m_mcr[1] && !m_mcr[4])}, "R2 R3 rts");
      cmp({15'h0, dtr_n}, {15'h0, !(m_mcr[0] && !m_mcr[4])}, "R2 R3 dtr");
      cmp({15'h0, msi}, {15'h0, m_ier[3] && (m_delta != 3'b000)}, "R7 msi");
      cmp(cfg, m_cfg, "R9 cfg");
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0; cyc(); idle();
  endtask

  task automatic rd_reg(input logic [2:0] a);
    addr = a; rd = 1'b1; wr = 1'b0; cyc(); idle();
  endtask

  task automatic do_reset(input logic s);
    strap = s; idle();
    @(negedge clk); #0.5;
    rst_n = 1'b0;
    chk_en = 1'b1;
    @(negedge clk);
    addr = 3'd4;
    #0.2;
    cmp({15'h0, rts_n}, 16'h1, "R1 rts");
    cmp({15'h0, dtr_n}, 16'h1, "R1 dtr");
    cmp({15'h0, msi}, 16'h0, "R1 msi");
    cmp({8'h0, rdata}, 16'h0, "R1 mcr");
    addr = 3'd6;
    #0.2;
    cmp({8'h0, rdata}, 16'h0, "R1 msr");
    cmp(cfg, B0, "R9 cfg in reset");
    cyc();
    rst_n = 1'b1;
    cyc(); cyc();
    @(negedge clk);
    cmp(cfg, s ? B1 : B0, "R9 strap capture");
    strap = ~s;
    cyc();
  endtask

  task automatic rand_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      int unsigned r;
      r = $urandom_range(0, 15);
      wr = (r < 3);
      rd = (r >= 3 && r < 7);
      case ($urandom_range(0, 5))
        0, 1: addr = 3'd6;
        2:    addr = 3'd4;
        3:    addr = 3'd1;
        default: addr = 3'($urandom_range(0, 7));
      endcase
      wdata = 8'($urandom);
      if (addr == 3'd4 && $urandom_range(0, 2) != 0) wdata[4] = 1'b0;
      if ($urandom_range(0, 7) == 0) cts_n = ~cts_n;
      if ($urandom_range(0, 7) == 0) dsr_n = ~dsr_n;
      if ($urandom_range(0, 9) == 0) dcd_n = ~dcd_n;
      if ($urandom_range(0, 3) == 0) strap = ~strap;
      cyc();
    end
    idle();
  endtask

  initial begin
    process::self().srandom(32'h5eed_0c1d);
    do_reset(1'b0);

    // R2 directed
    wr_reg(3'd4, 8'h03);
    @(negedge clk);
    cmp({14'h0, rts_n, dtr_n}, 16'h0, "R2 both asserted");
    // R3 directed
    wr_reg(3'd4, 8'h13);
    @(negedge clk);
    cmp({14'h0, rts_n, dtr_n}, 16'h3, "R3 loop forces high");

    // R8 directed: loop bits feed status, pins ignored
    wr_reg(3'd4, 8'h1F);
    cts_n = 1'b0; dsr_n = 1'b0; dcd_n = 1'b0;
    repeat (SYNC + 2) cyc();
    addr = 3'd6;
    @(negedge clk);
    cmp({12'h0, rdata[7:4]}, 16'hF, "R8 loop status");
    wr_reg(3'd4, 8'h10);
    @(negedge clk);
    addr = 3'd6;
    #0.2;
    cmp({12'h0, rdata[7:4]}, 16'h0, "R8 pins ignored");
    wr_reg(3'd4, 8'h00);
    repeat (SYNC + 2) cyc();
    rd_reg(3'd6);

    // R7 enable, R5 change on CTS release
    wr_reg(3'd1, 8'h08);
    cts_n = 1'b1;
    repeat (SYNC + 2) cyc();
    addr = 3'd6;
    @(negedge clk);
    cmp({15'h0, rdata[0]}, 16'h1, "R5 cts flag");
    cmp({15'h0, msi}, 16'h1, "R7 msi raised");
    rd_reg(3'd6);
    @(negedge clk);
    cmp({15'h0, msi}, 16'h0, "R7 msi cleared by read");

    // R6: change lands in the read cycle
    dsr_n = 1'b1;
    repeat (SYNC) cyc();
    addr = 3'd6; rd = 1'b1;
    cyc();
    @(negedge clk);
    cmp({15'h0, rdata[1]}, 16'h1, "R6 same-cycle change kept");
    cyc(); idle();

    rand_cycles(4000);
    do_reset(1'b1);
    rand_cycles(3000);
    do_reset(1'b0);
    rand_cycles(500);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule